// File: doc/BRIEF.md
# Synchronous Burst Static RAM Control Path

This block models the clocked control path of a synchronous burst static RAM. On every rising clock edge it samples three chip enables, a processor address strobe, a controller address strobe, a burst-advance input, a write qualifier, an address and write data. It classifies the cycle as one of four kinds. A deselect turns the data bus off and ends any burst. A load starts a burst at the external address. A next cycle moves to the following address in the burst. A hold cycle reuses the current address. The block also holds a small memory array and the burst address register.

Read data comes from a register that is loaded at the edge which samples the read. The data bus is driven only while that registered data is valid and the asynchronous output-enable pin is low. A host that holds the processor strobe inactive and uses only the controller strobe gets plain single accesses. A host that also holds the advance input active gets linear four-beat bursts.

Top module: `burst_sram_ctl`

## Requirements
- R1: The combined select is true only when `ce_hi` is 1 and `ce_lo_n` is 0. If `ce_pri_n` is 0, the combined select is false and either strobe is low, the cycle is a deselect: no memory access and no write.
- R2: `ce_pri_n` = 1 together with `strobe_ctl_n` = 0 is a deselect. After a deselect edge `dq_drive` is 0 and no burst is active.
- R3: `ce_pri_n` = 0, combined select true and `strobe_cpu_n` = 0 starts a read at `addr`. The memory is never written in this cycle, whatever `write_n` is.
- R4: `ce_pri_n` = 0, combined select true, `strobe_cpu_n` = 1 and `strobe_ctl_n` = 0 loads `addr`. It writes `wdata` when `write_n` = 0 and reads when `write_n` = 1.
- R5: With no load or deselect and `advance_n` = 0, an active burst accesses the next address. Only address bits [1:0] increment, wrapping 3 to 0, and the upper bits stay fixed.
- R6: With no load or deselect and `advance_n` = 1, an active burst accesses the current address again, as a read or a write chosen by `write_n`.
- R7: While `ce_pri_n` = 1, `strobe_cpu_n` has no effect: with `strobe_ctl_n` = 1 the burst continues or holds as in R5 and R6.
- R8: `out_en_n` acts without a clock. While it is 1, `dq_drive` is 0. While it is 0, `dq_drive` is 1 only while read data is presented.
- R9: Read data appears on `dq_out` with `dq_drive` = 1 right after the edge that samples the read cycle, and stays until the next edge.
- R10: A next or hold cycle with no active burst (after reset or a deselect) does no access, writes nothing and leaves `dq_drive` at 0.
- R11: Write data is stored at the edge that samples the write cycle, and a later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_pri_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Secondary enable, active high |
| ce_lo_n | input | 1 | Secondary enable, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, always a read |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, 0 = next address, 1 = hold |
| write_n | input | 1 | Write qualifier, 0 = write |
| addr | input | AW | External address |
| wdata | input | DW | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | DW | Read data register |
| dq_drive | output | 1 | Data bus driven, 0 = high impedance |

## Verification
Bursts are first written through the controller strobe and then read back with advance active. This separates a correct four-beat wrap from a carry into the upper address bits. Hold cycles are placed after advances to show whether the address stays put or moves. The processor strobe is applied with `write_n` low to confirm it never writes, and with the primary enable high to confirm it is ignored. Deselects caused by each enable pattern are each followed by an idle next/hold write and a readback, which separates a real deselect from one that still touches memory. A mid-cycle pulse on `out_en_n` shows that gating does not wait for a clock.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  // cycle classification made by the decoder
  typedef enum logic [1:0] {
    CYC_DESEL = 2'd0,
    CYC_LOAD  = 2'd1,
    CYC_NEXT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_t;

  // combined secondary select
  function automatic logic chip_sel(input logic hi, input logic lo_n);
    return hi & ~lo_n;
  endfunction

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
(
  input  logic ce_pri_n,
  input  logic ce_hi,
  input  logic ce_lo_n,
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  input  logic advance_n,
  input  logic write_n,
  output cyc_t kind,
  output logic wr
);

  logic sel;
  logic cpu_live;

  always_comb begin
    sel      = chip_sel(ce_hi, ce_lo_n);
    cpu_live = ~ce_pri_n & ~strobe_cpu_n;
    kind     = CYC_HOLD;
    wr       = ~write_n;
    if (ce_pri_n && !strobe_ctl_n) begin
      kind = CYC_DESEL;
      wr   = 1'b0;
    end else if (!ce_pri_n && !sel && (!strobe_cpu_n || !strobe_ctl_n)) begin
      kind = CYC_DESEL;
      wr   = 1'b0;
    end else if (cpu_live) begin
      kind = CYC_LOAD;
      wr   = 1'b0;
    end else if (!strobe_ctl_n) begin
      kind = CYC_LOAD;
    end else if (!advance_n) begin
      kind = CYC_NEXT;
    end else begin
      kind = CYC_HOLD;
    end
  end

endmodule

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_t          kind,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr,
  output logic          acc_en,
  output logic          burst_on,
  output logic [AW-1:0] cur_addr
);

  // linear wrap inside a 2**BB beat block
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r          = a;
    r[BB-1:0]  = a[BB-1:0] + BB'(1);
    return r;
  endfunction

  always_comb begin
    unique case (kind)
      CYC_LOAD: begin acc_addr = ext_addr;            acc_en = 1'b1;     end
      CYC_NEXT: begin acc_addr = step_addr(cur_addr); acc_en = burst_on; end
      CYC_HOLD: begin acc_addr = cur_addr;            acc_en = burst_on; end
      default:  begin acc_addr = cur_addr;            acc_en = 1'b0;     end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      cur_addr <= '0;
    end else begin
      if (kind == CYC_DESEL) burst_on <= 1'b0;
      else if (kind == CYC_LOAD) burst_on <= 1'b1;
      if (acc_en) cur_addr <= acc_addr;
    end
  end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          acc_en,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (acc_en && wr)  mem[addr] <= wdata;
    if (acc_en && !wr) rd_q      <= mem[addr];
  end

endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_pri_n,
  input  logic          ce_hi,
  input  logic          ce_lo_n,
  input  logic          strobe_cpu_n,
  input  logic          strobe_ctl_n,
  input  logic          advance_n,
  input  logic          write_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          out_en_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_drive
);

  cyc_t          kind;
  logic          wr;
  logic [AW-1:0] acc_addr;
  logic          acc_en;
  logic          burst_on;
  logic [AW-1:0] cur_addr;
  logic          rd_valid;

  bsram_decode u_dec (
    .ce_pri_n     (ce_pri_n),
    .ce_hi        (ce_hi),
    .ce_lo_n      (ce_lo_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .advance_n    (advance_n),
    .write_n      (write_n),
    .kind         (kind),
    .wr           (wr)
  );

  bsram_burst_addr #(.AW(AW), .BB(BB)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .ext_addr (addr),
    .acc_addr (acc_addr),
    .acc_en   (acc_en),
    .burst_on (burst_on),
    .cur_addr (cur_addr)
  );

  bsram_array #(.AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .acc_en (acc_en),
    .wr     (wr),
    .addr   (acc_addr),
    .wdata  (wdata),
    .rd_q   (dq_out)
  );

  // read data presented after the sampling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= acc_en & ~wr;
  end

  // asynchronous output gating
  assign dq_drive = rd_valid & ~out_en_n;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_pri_n,
  input logic          ce_hi,
  input logic          ce_lo_n,
  input logic          strobe_cpu_n,
  input logic          out_en_n,
  input logic          dq_drive,
  input cyc_t          kind,
  input logic          wr,
  input logic          acc_en,
  input logic          burst_on,
  input logic [AW-1:0] cur_addr
);

  // R2
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind == CYC_DESEL |=> !dq_drive);

  // R2
  desel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind == CYC_DESEL |=> !burst_on);

  // R10
  idle_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == CYC_NEXT || kind == CYC_HOLD) && !burst_on) |-> !acc_en);

  // R5
  next_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_NEXT && burst_on) |=>
      (cur_addr[AW-1:BB] == $past(cur_addr[AW-1:BB]) &&
       cur_addr[BB-1:0] == BB'($past(cur_addr[BB-1:0]) + BB'(1))));

  // R6
  hold_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_HOLD && burst_on) |=> $stable(cur_addr));

  // R3
  cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_pri_n && ce_hi && !ce_lo_n && !strobe_cpu_n) |=> (out_en_n || dq_drive));

  // R8
  oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_drive);

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr) |=> !dq_drive);

endmodule

bind burst_sram_ctl bsram_chk #(.AW(AW), .BB(BB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_pri_n     (ce_pri_n),
  .ce_hi        (ce_hi),
  .ce_lo_n      (ce_lo_n),
  .strobe_cpu_n (strobe_cpu_n),
  .out_en_n     (out_en_n),
  .dq_drive     (dq_drive),
  .kind         (kind),
  .wr           (wr),
  .acc_en       (acc_en),
  .burst_on     (burst_on),
  .cur_addr     (cur_addr)
);

// File: tb/burst_sram_ctl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctl_bench;

  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_pri_n = 1'b1, ce_hi = 1'b1, ce_lo_n = 1'b0;
  logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1;
  logic          advance_n = 1'b1, write_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  burst_sram_ctl #(.AW(AW), .DW(DW)) u_burst_sram_ctl (
    .clk(clk), .rst_n(rst_n), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .advance_n(advance_n), .write_n(write_n), .addr(addr), .wdata(wdata),
    .out_en_n(out_en_n), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    bit          drv;
    logic [15:0] dat;
    string       tag;
  } exp_t;
  exp_t exq[$];

  // reference state kept from the requirements
  logic [15:0] m_mem [64];
  int          m_cur = 0;
  bit          m_on  = 0;

  task automatic chk(input bit ok, input string tag, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // driver: apply one cycle, predict the bus after its edge
  task automatic step(input string tag, input bit p, input bit h, input bit l,
                      input bit sp, input bit sc, input bit av, input bit w,
                      input int a, input logic [15:0] d);
    bit   sel_ok, load, dsel, wrc, acc;
    int   aa;
    exp_t e;
    @(negedge clk);
    ce_pri_n = p; ce_hi = h; ce_lo_n = l; strobe_cpu_n = sp;
    strobe_ctl_n = sc; advance_n = av; write_n = w;
    addr = AW'(a); wdata = d;
    sel_ok = h && !l;
    dsel = (p && !sc) || (!p && !sel_ok && (!sp || !sc));
    load = !dsel && !p && (!sp || !sc);
    wrc  = !w && !(!p && !sp);
    aa   = m_cur;
    acc  = 0;
    if (dsel) m_on = 0;
    else if (load) begin aa = a; acc = 1; m_on = 1; end
    else if (m_on) begin
      acc = 1;
      if (!av) aa = (m_cur / 4) * 4 + ((m_cur + 1) % 4);
    end
    if (acc) m_cur = aa;
    if (acc && wrc) m_mem[aa] = d;
    e.drv = acc && !wrc;
    e.dat = e.drv ? m_mem[aa] : 16'h0;
    e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic ld_w(input string t, input int a, input logic [15:0] d);
    step(t, 0, 1, 0, 1, 0, 1, 0, a, d);
  endtask
  task automatic ld_r(input string t, input int a);
    step(t, 0, 1, 0, 1, 0, 1, 1, a, 16'h0);
  endtask
  task automatic nx_w(input string t, input logic [15:0] d);
    step(t, 0, 1, 0, 1, 1, 0, 0, 0, d);
  endtask
  task automatic nx_r(input string t);
    step(t, 0, 1, 0, 1, 1, 0, 1, 0, 16'h0);
  endtask
  task automatic hd_r(input string t);
    step(t, 0, 1, 0, 1, 1, 1, 1, 0, 16'h0);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (exq.size() > 0) begin
      exp_t e;
      e = exq.pop_front();
      if (e.drv)
        chk(dq_drive === 1'b1 && dq_out === e.dat, e.tag,
            $sformatf("drive=%b data=%h expected drive=1 data=%h", dq_drive, dq_out, e.dat));
      else
        chk(dq_drive === 1'b0, e.tag,
            $sformatf("drive=%b expected 0", dq_drive));
    end
  end

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk(dq_drive === 1'b0, "R2 reset", $sformatf("drive=%b expected 0", dq_drive));

    // R10 idle next/hold before any burst
    step("R10 idle next write", 0, 1, 0, 1, 1, 0, 0, 5, 16'hdead);

    // R4 R11 R5 write burst 8..11
    ld_w("R4 R11 load write", 8, 16'ha000);
    nx_w("R5 next write", 16'ha001);
    nx_w("R5 next write", 16'ha002);
    nx_w("R5 next write", 16'ha003);

    // R4 R9 R5 read burst with wrap, then R6 hold
    ld_r("R4 R9 load read", 8);
    nx_r("R5 R9 next read");
    nx_r("R5 next read");
    nx_r("R5 next read");
    nx_r("R5 wrap read");
    hd_r("R6 hold read");
    hd_r("R6 hold read");

    // R5 write burst 14,15,12,13 wraps
    ld_w("R11 load write", 14, 16'hb002);
    nx_w("R5 next write", 16'hb003);
    nx_w("R5 wrap write", 16'hb000);
    nx_w("R5 next write", 16'hb001);
    // R6 hold write at 13 then rewrite
    step("R6 hold write", 0, 1, 0, 1, 1, 1, 0, 0, 16'hb111);

    // R3 processor strobe with write_n low still reads
    step("R3 cpu read", 0, 1, 0, 0, 1, 1, 0, 13, 16'h5555);
    nx_r("R3 R5 next read");
    nx_r("R5 next read");
    nx_r("R5 wrap read");

    // R7 primary high: processor strobe ignored, burst continues
    step("R7 cpu ignored", 1, 1, 0, 0, 1, 0, 1, 40, 16'h0);

    // R8 asynchronous gating mid-cycle
    @(negedge clk);
    out_en_n = 1'b1;
    #1 chk(dq_drive === 1'b0, "R8 oe high", $sformatf("drive=%b expected 0", dq_drive));
    out_en_n = 1'b0;
    #1 chk(dq_drive === 1'b1, "R8 oe low", $sformatf("drive=%b expected 1", dq_drive));

    // R1 combined select false deselects
    step("R1 ce_hi low cpu", 0, 0, 0, 0, 1, 1, 1, 8, 16'h0);
    step("R10 next after desel", 0, 1, 0, 1, 1, 0, 0, 0, 16'h7777);
    step("R1 ce_lo_n high ctl write", 0, 1, 1, 1, 0, 1, 0, 8, 16'hffff);
    ld_r("R1 readback", 8);

    // R2 primary high with controller strobe deselects
    ld_r("R9 read", 9);
    step("R2 desel", 1, 1, 0, 1, 0, 1, 1, 9, 16'h0);
    step("R10 hold after desel", 0, 1, 0, 1, 1, 1, 0, 0, 16'h3333);
    ld_r("R2 readback", 9);

    // simple single-access mode
    ld_r("R9 single", 10);
    ld_r("R9 single", 12);
    ld_r("R11 single", 13);

    repeat (3) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule